// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It sits next to an external DAC and an external comparator. When software sets the go bit, the block can first wait an acquisition interval. It then walks a binary search from the most significant bit down to the least significant bit, one trial per period of a conversion clock divided from the system clock. At the end it places the code in a 16-bit result word, packed toward either the low or the high end.

For each trial, the block drives a trial code to the DAC. Near the end of each divided period it samples the comparator, which reports whether the analog input lies above the DAC level. The go bit reads back as 1 for the whole conversion. Hardware clears it in the same cycle that the result appears and that the one-cycle done pulse fires.

Top module: `sar_seq`

## Requirements
- R1: After reset, goBusy, done, result and dacCode are all 0. The remembered channel is 0.
- R2: A goSet pulse while idle makes goBusy read 1 from the next cycle. goBusy stays 1 until the last trial is decided. Hardware then clears it, and in that same cycle done is 1 for exactly one cycle.
- R3: During an acquisition wait, dacCode is 0. The first trial code of every search has only its MSB set, which is half scale.
- R4: Each decision keeps the bit under trial when cmpAbove is 1 (input above the DAC level) and clears it when cmpAbove is 0. The next lower bit is then set as the new trial. For a 10-bit input of 804.2 LSB, the trial codes start 0x200, 0x300, 0x380, 0x340, and the result is 804.
- R5: Each trial lasts one divided period: 2 system clocks for divSel=0, 8 for divSel=1, and 32 for divSel=2 or 3. The comparator is sampled in the last cycle of the period. Without acquisition, goBusy stays high for RES_W periods.
- R6: If chanSel differs from the channel of the previous conversion and acqCycles is nonzero, goBusy is extended by acqCycles system clocks before the first trial. With the same channel, or with acqCycles=0, no wait is inserted.
- R7: When leftJustify is 0, the code occupies result[RES_W-1:0] and the upper bits are 0. When leftJustify is 1, the code occupies result[15:16-RES_W] and the lower bits are 0.
- R8: divSel, leftJustify, chanSel and acqCycles are captured at the accepted goSet. A goSet or a setting change during a conversion has no effect on its timing or its result.
- R9: An input above every DAC level gives an all-ones code. An input below the first LSB gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| goSet | input | 1 | software write of 1 to the go bit |
| divSel | input | 2 | conversion clock divider select |
| leftJustify | input | 1 | 1 packs the result toward bit 15 |
| chanSel | input | CH_W | selected analog channel |
| acqCycles | input | ACQ_W | acquisition wait in system clocks |
| cmpAbove | input | 1 | comparator: input above DAC level |
| dacCode | output | RES_W | trial code driven to the DAC |
| result | output | 16 | justified conversion result |
| goBusy | output | 1 | go bit read-back, 1 while converting |
| done | output | 1 | one-cycle completion pulse |

## Verification
The bench uses the default parameters: RES_W=10, CH_W=2 and ACQ_W=8. With these, the justification padding is six bits and the trial sequence of the worked example can be observed. Acquisition counts are kept to single digits. Even at the divide-by-32 setting, each conversion stays within a few hundred cycles, so every divider setting, both packings, both full-scale ends and the acquisition-skip conditions fit into one short run.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int DIV_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV} sarState_t;

  typedef struct packed {
    logic clr;
    logic loadMsb;
    logic decide;
    logic commit;
    logic leftJust;
  } sarStrobe_t;

  function automatic logic [DIV_W-1:0] divLast(input logic [1:0] sel);
    case (sel)
      2'd0:    divLast = DIV_W'(1);
      2'd1:    divLast = DIV_W'(7);
      default: divLast = DIV_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CH_W  = 2,
  parameter int ACQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             goSet,
  input  logic [1:0]       divSel,
  input  logic             leftJustify,
  input  logic [CH_W-1:0]  chanSel,
  input  logic [ACQ_W-1:0] acqCycles,
  output sarStrobe_t       stb,
  output logic             goBusy,
  output logic             done
);
  localparam int STEP_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  sarState_t        state;
  logic [DIV_W-1:0] divCnt, divEnd;
  logic [ACQ_W-1:0] acqCnt, acqLen;
  logic [STEP_W-1:0] stepCnt;
  logic [CH_W-1:0]  lastChan;
  logic             leftQ;
  logic             startAcq, periodEnd, lastStep;

  assign startAcq  = (chanSel != lastChan) && (acqCycles != '0);
  assign periodEnd = (state == ST_CONV) && (divCnt == divEnd);
  assign lastStep  = (stepCnt == STEP_W'(RES_W - 1));

  always_comb begin
    stb          = '0;
    stb.leftJust = leftQ;
    case (state)
      ST_IDLE: if (goSet) begin
        stb.clr     = startAcq;
        stb.loadMsb = !startAcq;
      end
      ST_ACQ:  stb.loadMsb = (acqCnt == acqLen - 1'b1);
      ST_CONV: begin
        stb.decide = periodEnd;
        stb.commit = periodEnd && lastStep;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      divEnd   <= '0;
      acqCnt   <= '0;
      acqLen   <= '0;
      stepCnt  <= '0;
      lastChan <= '0;
      leftQ    <= 1'b0;
      goBusy   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (goSet) begin
          lastChan <= chanSel;
          divEnd   <= divLast(divSel);
          leftQ    <= leftJustify;
          acqLen   <= acqCycles;
          acqCnt   <= '0;
          divCnt   <= '0;
          stepCnt  <= '0;
          goBusy   <= 1'b1;
          state    <= startAcq ? ST_ACQ : ST_CONV;
        end
        ST_ACQ: begin
          if (acqCnt == acqLen - 1'b1) state <= ST_CONV;
          else                         acqCnt <= acqCnt + 1'b1;
        end
        ST_CONV: begin
          if (periodEnd) begin
            divCnt <= '0;
            if (lastStep) begin
              state  <= ST_IDLE;
              goBusy <= 1'b0;
              done   <= 1'b1;
            end else begin
              stepCnt <= stepCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  go_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (goSet && !goBusy) |=> goBusy);
  // R2
  done_with_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(goBusy) |-> done);
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV) |-> (divCnt <= divEnd));
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sarStrobe_t       stb,
  input  logic             cmpAbove,
  output logic [RES_W-1:0] dacCode,
  output logic [15:0]      result
);
  localparam int PAD = 16 - RES_W;
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] trial, mask, kept;

  assign kept    = cmpAbove ? trial : (trial & ~mask);
  assign dacCode = trial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial  <= '0;
      mask   <= '0;
      result <= '0;
    end else begin
      if (stb.clr) begin
        trial <= '0;
        mask  <= '0;
      end else if (stb.loadMsb) begin
        trial <= MSB_ONE;
        mask  <= MSB_ONE;
      end else if (stb.decide) begin
        trial <= kept | (mask >> 1);
        mask  <= mask >> 1;
      end
      if (stb.commit)
        result <= stb.leftJust ? (16'(kept) << PAD) : 16'(kept);
    end
  end

  // R4
  mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask));
  // R5
  trial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.clr || stb.loadMsb || stb.decide) |=> $stable(trial));

  generate
    if (PAD > 0) begin : g_pad
      // R7
      left_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.commit && stb.leftJust) |=> (result[PAD-1:0] == '0));
    end
  endgenerate
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CH_W  = 2,
  parameter int ACQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             goSet,
  input  logic [1:0]       divSel,
  input  logic             leftJustify,
  input  logic [CH_W-1:0]  chanSel,
  input  logic [ACQ_W-1:0] acqCycles,
  input  logic             cmpAbove,
  output logic [RES_W-1:0] dacCode,
  output logic [15:0]      result,
  output logic             goBusy,
  output logic             done
);
  sarStrobe_t stb;

  sar_ctrl #(.RES_W(RES_W), .CH_W(CH_W), .ACQ_W(ACQ_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .goSet(goSet), .divSel(divSel),
    .leftJustify(leftJustify), .chanSel(chanSel), .acqCycles(acqCycles),
    .stb(stb), .goBusy(goBusy), .done(done)
  );

  sar_datapath #(.RES_W(RES_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cmpAbove(cmpAbove),
    .dacCode(dacCode), .result(result)
  );
endmodule

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;
  localparam int RES_W = 10;
  localparam int CH_W  = 2;
  localparam int ACQ_W = 8;

  typedef struct packed {
    logic [17:0] vin;   // input in 1/256 LSB
    logic [1:0]  div;
    logic        left;
    logic [1:0]  chan;
    logic [7:0]  acq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{vin: 18'd205875,            div: 2'd0, left: 1'b0, chan: 2'd0, acq: 8'd5},
    '{vin: 18'(1023*256 + 200),   div: 2'd1, left: 1'b1, chan: 2'd1, acq: 8'd6},
    '{vin: 18'd100,               div: 2'd2, left: 1'b0, chan: 2'd1, acq: 8'd9},
    '{vin: 18'(300*256 + 77),     div: 2'd3, left: 1'b1, chan: 2'd2, acq: 8'd0},
    '{vin: 18'(513*256 + 10),     div: 2'd0, left: 1'b1, chan: 2'd3, acq: 8'd4},
    '{vin: 18'(77*256 + 250),     div: 2'd1, left: 1'b0, chan: 2'd0, acq: 8'd3}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             goSet = 1'b0;
  logic [1:0]       divSel = '0;
  logic             leftJustify = 1'b0;
  logic [CH_W-1:0]  chanSel = '0;
  logic [ACQ_W-1:0] acqCycles = '0;
  logic             cmpAbove;
  logic [RES_W-1:0] dacCode;
  logic [15:0]      result;
  logic             goBusy, done;
  logic [17:0]      vinFx = '0;

  int checks = 0;
  int fails  = 0;
  logic [CH_W-1:0] lastChanModel = '0;

  logic [RES_W-1:0] trialLog [RES_W];
  int               logN = 0;
  logic [RES_W-1:0] prevCode = '0;

  always #2.5 clk = ~clk;

  // comparator model: input strictly above the DAC level
  assign cmpAbove = vinFx > {dacCode, 8'd0};

  sar_seq #(.RES_W(RES_W), .CH_W(CH_W), .ACQ_W(ACQ_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .goSet(goSet), .divSel(divSel),
    .leftJustify(leftJustify), .chanSel(chanSel), .acqCycles(acqCycles),
    .cmpAbove(cmpAbove), .dacCode(dacCode), .result(result),
    .goBusy(goBusy), .done(done)
  );

  always @(negedge clk) begin
    if (goBusy && dacCode != '0 && dacCode != prevCode && logN < RES_W) begin
      trialLog[logN] <= dacCode;
      logN <= logN + 1;
    end
    prevCode <= goBusy ? dacCode : '0;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratioOf(input logic [1:0] d);
    return (d == 2'd0) ? 2 : (d == 2'd1) ? 8 : 32;
  endfunction

  task automatic runConv(input vec_t v, input int extraGoAt, input string tag);
    int busyCnt = 0;
    int expBusy;
    logic [RES_W-1:0] code;
    logic [15:0] expRes;
    bit acqExp;
    acqExp  = (v.chan != lastChanModel) && (v.acq != 0);
    expBusy = (acqExp ? int'(v.acq) : 0) + RES_W * ratioOf(v.div);
    code    = (v.vin[17:8] > 10'(2**RES_W - 1)) ? '1 : RES_W'(v.vin[17:8]);
    expRes  = v.left ? (16'(code) << (16 - RES_W)) : 16'(code);
    lastChanModel = v.chan;
    @(negedge clk);
    vinFx = v.vin; divSel = v.div; leftJustify = v.left;
    chanSel = v.chan; acqCycles = v.acq; goSet = 1'b1;
    @(negedge clk);
    goSet = 1'b0;
    while (goBusy && busyCnt < 2000) begin
      busyCnt++;
      if (extraGoAt != 0 && busyCnt == extraGoAt) begin
        goSet = 1'b1; divSel = 2'd2; leftJustify = ~v.left;
        chanSel = ~v.chan; acqCycles = 8'd50;
      end else begin
        goSet = 1'b0;
      end
      @(negedge clk);
    end
    goSet = 1'b0;
    check({tag, " R5/R6 busy cycles"}, busyCnt, expBusy);
    check({tag, " R2 done with clear"}, done, 1);
    check({tag, " R4/R7 result"}, result, expRes);
    @(negedge clk);
    check({tag, " R2 done one cycle"}, done, 0);
    check({tag, " R2 busy stays clear"}, goBusy, 0);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 goBusy", goBusy, 0);
    check("R1 done", done, 0);
    check("R1 result", result, 0);
    check("R1 dacCode", dacCode, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      runConv(VECS[i], 0, $sformatf("vec%0d", i));
      if (i == 0) begin
        // R3 first trial half scale, R4 worked search order
        check("R3 first trial", trialLog[0], 10'h200);
        check("R4 trial 2", trialLog[1], 10'h300);
        check("R4 trial 3", trialLog[2], 10'h380);
        check("R4 trial 4", trialLog[3], 10'h340);
        check("R4 trial count", logN, RES_W);
      end
    end

    // R3 code is zero during acquisition, then half scale
    begin
      vec_t a;
      a = '{vin: 18'(400*256 + 9), div: 2'd0, left: 1'b0, chan: 2'd2, acq: 8'd6};
      lastChanModel = a.chan;
      @(negedge clk);
      vinFx = a.vin; divSel = a.div; leftJustify = a.left;
      chanSel = a.chan; acqCycles = a.acq; goSet = 1'b1;
      @(negedge clk);
      goSet = 1'b0;
      check("R3 acq dac zero", dacCode, 0);
      repeat (6) @(negedge clk);
      check("R3 half scale after acq", dacCode, 10'h200);
      while (goBusy) @(negedge clk);
      check("R9 mid result", result, 400);
      @(negedge clk);
    end

    // R8 go and setting changes mid-conversion are ignored
    runConv('{vin: 18'(600*256 + 128), div: 2'd0, left: 1'b0, chan: 2'd2, acq: 8'd0},
            3, "R8 busy go");
    // R6 same channel again, nonzero wait, no acquisition
    runConv('{vin: 18'(1*256 + 30), div: 2'd0, left: 1'b1, chan: 2'd2, acq: 8'd7},
            0, "R6 same chan");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule